// File: doc/BRIEF.md
# Ping-Pong Transfer-Curve Table Controller

This block holds a piecewise-linear transfer curve as a table of per-channel base and slope values, stored twice: bank A and bank B. While one bank feeds the pixel lookup port, software fills the other through a small register interface. It chooses the target bank and a channel enable mask, sets the starting entry, and then streams words into a single data register. An internal word counter and entry index place each word automatically.

Two streaming formats are supported. In the split format every entry is six words: three bases followed by three slopes. In the packed format every entry is three words, each holding both the base and the slope of one channel. When loading is done, software writes the mode register to point at the loaded bank. The change is committed on the next frame-start strobe, so a frame never mixes two curves. The lookup port returns the base and slope for an entry index and a channel from the live bank, one cycle after the request. In bypass it passes the input straight through.

Top module: `gamma_pingpong_lut`

## Requirements
- R1: After reset, live_status is 0, wr_err is 0, lk_base and lk_delta are 0, the mode register is 0, the entry index and word position are 0, the channel mask is 0, and every entry of both banks reads as 0.
- R2: Register address 0 holds the mode in bits 1:0. Mode 0 selects bypass, 1 selects bank A and 2 selects bank B. Mode 3 is treated as bypass. live_status only ever shows 0 (bypass), 1 (bank A) or 2 (bank B).
- R3: A mode write does not change live_status or the lookup source by itself. Both change on the clock edge where frame_start is high, and take the mode value that was registered before that edge.
- R4: Register address 1 bit 4 selects the bank that data writes go to: 0 for bank A, 1 for bank B.
- R5: Register address 1 bits 2:0 form a channel enable mask, with bit 0 for red, bit 1 for green and bit 2 for blue. A word aimed at a disabled channel leaves that channel's entry unchanged.
- R6: With address 1 bit 8 clear (split format), writes to register address 3 fill an entry in the order red base, green base, blue base, red slope, green slope, blue slope. Bases take data bits 13:0 and slopes take bits 9:0. The entry index advances after the sixth word.
- R7: With address 1 bit 8 set (packed format), each data word carries the slope in bits 23:14 and the base in bits 13:0. Three words fill an entry, in the order red, green, blue, and the index advances after the third word.
- R8: A write to register address 2 loads the entry index from its low bits and restarts at the first word of an entry. A write to address 1 also restarts at the first word.
- R9: A data word aimed at the live bank changes no stored value and sets wr_err. wr_err stays set until reset. The word position and index still advance.
- R10: Lookups have one cycle of latency. lk_chan 0, 1 and 2 select red, green and blue, and the block returns the base and slope at lk_idx from the live bank. lk_chan 3 returns zeros. In bypass, lk_base equals lk_in and lk_delta is 0.
- R11: The entry index wraps from the last entry (31 by default) back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 mode, 1 write config, 2 index, 3 data |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame-start strobe that commits the mode |
| lk_idx | input | IDX_W | Lookup entry index |
| lk_chan | input | 2 | Lookup channel: 0 red, 1 green, 2 blue |
| lk_in | input | BASE_W | Pass-through value used in bypass |
| lk_base | output | BASE_W | Looked-up base, one cycle later |
| lk_delta | output | DELTA_W | Looked-up slope, one cycle later |
| live_status | output | 2 | Committed bank: 0 bypass, 1 A, 2 B |
| wr_err | output | 1 | Sticky flag for a write aimed at the live bank |

## Verification
The hardest situations to reach are the ones where the word counter and the entry index are out of step with a clean entry boundary. Examples are an index rewrite in the middle of an entry, a stream that runs past the last entry, and rejected words aimed at the live bank that still have to keep the stream aligned. The stimulus produces each of these on purpose. It abandons a packed entry after two words and rewrites it, loads entry 31 and carries on into entry 0, and sends a rejected entry to the live bank followed by an accepted one to the other bank. Each effect is then made visible by switching banks at a frame strobe and reading back specific entries, including entries that must still be zero.

// File: rtl/gpl_pkg.sv
package gpl_pkg;

    typedef enum logic [1:0] {
        LIVE_BYP = 2'd0,
        LIVE_A   = 2'd1,
        LIVE_B   = 2'd2
    } live_e;

    localparam logic [1:0] REG_MODE  = 2'd0;
    localparam logic [1:0] REG_WCFG  = 2'd1;
    localparam logic [1:0] REG_INDEX = 2'd2;
    localparam logic [1:0] REG_DATA  = 2'd3;

    localparam int NUM_CH       = 3;
    localparam int NUM_BANKS    = 2;
    localparam int WORDS_SPLIT  = 2 * NUM_CH;
    localparam int WORDS_PACKED = NUM_CH;
    localparam int WORD_W       = $clog2(WORDS_SPLIT);
    localparam int WSEL_BIT     = 4;
    localparam int FMT_BIT      = 8;

    function automatic live_e decode_mode(input logic [1:0] m);
        case (m)
            2'd1:    return LIVE_A;
            2'd2:    return LIVE_B;
            default: return LIVE_BYP;
        endcase
    endfunction

endpackage

// File: rtl/gpl_live_ctrl.sv
module gpl_live_ctrl
    import gpl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] mode,
    output live_e      live
);

    typedef struct packed {
        live_e live;
    } ctl_t;

    ctl_t d, q;

    always_comb begin
        d = q;
        if (frame_start) begin
            d.live = decode_mode(mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.live <= LIVE_BYP;
        end else begin
            q <= d;
        end
    end

    assign live = q.live;

    // R2: only the three legal status codes ever appear
    assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.live inside {LIVE_BYP, LIVE_A, LIVE_B});

    // R3: the committed bank moves only on a frame strobe
    assert_switch_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.live != $past(q.live)) |-> $past(frame_start));

endmodule

// File: rtl/gpl_write_seq.sv
module gpl_write_seq
    import gpl_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int BASE_W  = 14,
    parameter int DELTA_W = 10,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  live_e              live,
    output logic [1:0]         mode,
    output logic               wr_bank,
    output logic [NUM_CH-1:0]  base_we,
    output logic [NUM_CH-1:0]  delta_we,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [BASE_W-1:0]  wr_base,
    output logic [DELTA_W-1:0] wr_delta,
    output logic               err
);

    localparam logic [WORD_W-1:0] LAST_SPLIT  = WORD_W'(WORDS_SPLIT - 1);
    localparam logic [WORD_W-1:0] LAST_PACKED = WORD_W'(WORDS_PACKED - 1);

    typedef struct packed {
        logic [1:0]        mode;
        logic [NUM_CH-1:0] mask;
        logic              sel;
        logic              packed_fmt;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
        logic              err;
    } seq_t;

    seq_t d, q;
    logic [WORD_W-1:0] last_word;
    logic              hits_live;
    logic              unused_hi;

    assign unused_hi = ^cfg_wdata[DATA_W-1:BASE_W+DELTA_W];

    always_comb begin
        d         = q;
        base_we   = '0;
        delta_we  = '0;
        last_word = q.packed_fmt ? LAST_PACKED : LAST_SPLIT;
        hits_live = (!q.sel && live == LIVE_A) || (q.sel && live == LIVE_B);
        if (cfg_we) begin
            case (cfg_addr)
                REG_MODE: d.mode = cfg_wdata[1:0];
                REG_WCFG: begin
                    d.mask       = cfg_wdata[NUM_CH-1:0];
                    d.sel        = cfg_wdata[WSEL_BIT];
                    d.packed_fmt = cfg_wdata[FMT_BIT];
                    d.word       = '0;
                end
                REG_INDEX: begin
                    d.idx  = cfg_wdata[IDX_W-1:0];
                    d.word = '0;
                end
                default: begin
                    if (hits_live) begin
                        d.err = 1'b1;
                    end else begin
                        for (int c = 0; c < NUM_CH; c++) begin
                            if (q.mask[c]) begin
                                if (q.packed_fmt) begin
                                    if (q.word == WORD_W'(c)) begin
                                        base_we[c]  = 1'b1;
                                        delta_we[c] = 1'b1;
                                    end
                                end else begin
                                    if (q.word == WORD_W'(c))          base_we[c]  = 1'b1;
                                    if (q.word == WORD_W'(c + NUM_CH)) delta_we[c] = 1'b1;
                                end
                            end
                        end
                    end
                    if (q.word == last_word) begin
                        d.word = '0;
                        d.idx  = q.idx + IDX_W'(1);
                    end else begin
                        d.word = q.word + WORD_W'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mode     = q.mode;
    assign wr_bank  = q.sel;
    assign wr_idx   = q.idx;
    assign err      = q.err;
    assign wr_base  = cfg_wdata[BASE_W-1:0];
    assign wr_delta = q.packed_fmt ? cfg_wdata[BASE_W +: DELTA_W] : cfg_wdata[DELTA_W-1:0];

    // R6: the word position never leaves the current entry layout
    assert_word_in_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.word <= (q.packed_fmt ? LAST_PACKED : LAST_SPLIT));

    // R6: the last word of an entry steps the index by one
    assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_DATA && q.word == last_word) |=>
        (q.idx == $past(q.idx) + IDX_W'(1)));

    // R9: the error flag never clears outside reset
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.err) |-> q.err);

endmodule

// File: rtl/gpl_bank_store.sv
module gpl_bank_store
    import gpl_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int BASE_W  = 14,
    parameter int DELTA_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_bank,
    input  logic [NUM_CH-1:0]  base_we,
    input  logic [NUM_CH-1:0]  delta_we,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BASE_W-1:0]  wr_base,
    input  logic [DELTA_W-1:0] wr_delta,
    input  live_e              live,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic [1:0]         lk_chan,
    input  logic [BASE_W-1:0]  lk_in,
    output logic [BASE_W-1:0]  lk_base,
    output logic [DELTA_W-1:0] lk_delta
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [BASE_W-1:0]  base;
        logic [DELTA_W-1:0] delta;
    } out_t;

    logic [BASE_W-1:0]  rd_base  [NUM_BANKS][NUM_CH];
    logic [DELTA_W-1:0] rd_delta [NUM_BANKS][NUM_CH];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic [BASE_W-1:0]  base_mem  [DEPTH];
            logic [DELTA_W-1:0] delta_mem [DEPTH];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        base_mem[i]  <= '0;
                        delta_mem[i] <= '0;
                    end
                end else begin
                    if (base_we[c] && (wr_bank == 1'(b)))  base_mem[wr_idx]  <= wr_base;
                    if (delta_we[c] && (wr_bank == 1'(b))) delta_mem[wr_idx] <= wr_delta;
                end
            end

            assign rd_base[b][c]  = base_mem[lk_idx];
            assign rd_delta[b][c] = delta_mem[lk_idx];
        end
    end

    out_t d, q;
    logic bank_b;

    always_comb begin
        d      = '0;
        bank_b = (live == LIVE_B);
        if (live == LIVE_BYP) begin
            d.base = lk_in;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (lk_chan == 2'(c)) begin
                    d.base  = rd_base[bank_b][c];
                    d.delta = rd_delta[bank_b][c];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lk_base  = q.base;
    assign lk_delta = q.delta;

    // R9: no write strobe ever reaches the bank that is live
    assert_live_bank_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((live != LIVE_BYP) && ((|base_we) || (|delta_we))) |-> (wr_bank != (live == LIVE_B)));

endmodule

// File: rtl/gamma_pingpong_lut.sv
module gamma_pingpong_lut
    import gpl_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int BASE_W  = 14,
    parameter int DELTA_W = 10,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               frame_start,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic [1:0]         lk_chan,
    input  logic [BASE_W-1:0]  lk_in,
    output logic [BASE_W-1:0]  lk_base,
    output logic [DELTA_W-1:0] lk_delta,
    output logic [1:0]         live_status,
    output logic               wr_err
);

    live_e              live;
    logic [1:0]         mode;
    logic               wr_bank;
    logic [NUM_CH-1:0]  base_we;
    logic [NUM_CH-1:0]  delta_we;
    logic [IDX_W-1:0]   wr_idx;
    logic [BASE_W-1:0]  wr_base;
    logic [DELTA_W-1:0] wr_delta;

    gpl_write_seq #(
        .IDX_W(IDX_W), .BASE_W(BASE_W), .DELTA_W(DELTA_W), .DATA_W(DATA_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .live(live), .mode(mode), .wr_bank(wr_bank),
        .base_we(base_we), .delta_we(delta_we), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_delta(wr_delta), .err(wr_err)
    );

    gpl_live_ctrl u_live (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode(mode), .live(live)
    );

    gpl_bank_store #(
        .IDX_W(IDX_W), .BASE_W(BASE_W), .DELTA_W(DELTA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_bank(wr_bank), .base_we(base_we),
        .delta_we(delta_we), .wr_idx(wr_idx), .wr_base(wr_base), .wr_delta(wr_delta),
        .live(live), .lk_idx(lk_idx), .lk_chan(lk_chan), .lk_in(lk_in),
        .lk_base(lk_base), .lk_delta(lk_delta)
    );

    assign live_status = live;

endmodule

// File: tb/gamma_pingpong_lut_test.sv
module gamma_pingpong_lut_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic [4:0]  lk_idx = '0;
    logic [1:0]  lk_chan = '0;
    logic [13:0] lk_in = '0;
    logic [13:0] lk_base;
    logic [9:0]  lk_delta;
    logic [1:0]  live_status;
    logic        wr_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int    b;
        int    d;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    logic lk_v = 1'b0;
    logic pend = 1'b0;

    always #5 clk = ~clk;

    gamma_pingpong_lut uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .lk_idx(lk_idx),
        .lk_chan(lk_chan), .lk_in(lk_in), .lk_base(lk_base), .lk_delta(lk_delta),
        .live_status(live_status), .wr_err(wr_err)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pk(input int dl, input int bs);
        return (32'(dl) << 14) | 32'(bs);
    endfunction

    // all tasks start and end at a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic look(input int idx, input int ch, input int inv,
                        input int eb, input int ed, input string tag);
        exp_t e;
        lk_idx = 5'(idx); lk_chan = 2'(ch); lk_in = 14'(inv); lk_v = 1'b1;
        e.b = eb; e.d = ed; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        lk_v = 1'b0;
    endtask

    // scoreboard monitor: a request issued before a rising edge is
    // compared at the falling edge that follows it
    always @(posedge clk) pend <= lk_v;

    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(int'(lk_base), e.b, {e.tag, " base"});
            chk(int'(lk_delta), e.d, {e.tag, " delta"});
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(live_status, 0, "R1 status");
        chk(wr_err, 0, "R1 err");
        chk(lk_base, 0, "R1 base");
        chk(lk_delta, 0, "R1 delta");
        look(3, 0, 16'h1234, 16'h1234, 0, "R10 bypass pass-through");

        // split format into bank B (sel=1, mask=7)
        wr(2'd1, 32'h017);
        wr(2'd2, 0);
        wr(2'd3, 32'h0101); wr(2'd3, 32'h0202); wr(2'd3, 32'h0303);
        wr(2'd3, 32'h011);  wr(2'd3, 32'h022);  wr(2'd3, 32'h033);
        wr(2'd3, 32'h1111); wr(2'd3, 32'h2222); wr(2'd3, 32'h3333);
        wr(2'd3, 32'h0AA);  wr(2'd3, 32'h0BB);  wr(2'd3, 32'h0CC);
        wr(2'd0, 2);
        chk(live_status, 0, "R3 no switch before frame");
        look(0, 0, 16'h0777, 16'h0777, 0, "R3 still bypass before frame");
        frame();
        chk(live_status, 2, "R3 R2 status bank B after frame");
        look(0, 0, 0, 16'h0101, 16'h011, "R6 R4 B e0 red");
        look(0, 2, 0, 16'h0303, 16'h033, "R6 B e0 blue");
        look(1, 1, 0, 16'h2222, 16'h0BB, "R6 B e1 green");
        look(1, 3, 0, 0, 0, "R10 chan3 zero");

        // packed format into bank A (sel=0)
        wr(2'd1, 32'h107);
        wr(2'd2, 5);
        wr(2'd3, pk(16'h155, 16'h2AAA)); wr(2'd3, pk(16'h0F0, 16'h1234)); wr(2'd3, pk(16'h3FF, 16'h3FFF));
        wr(2'd1, 32'h105);
        wr(2'd3, pk(16'h001, 16'h0010)); wr(2'd3, pk(16'h002, 16'h0020)); wr(2'd3, pk(16'h003, 16'h0030));
        wr(2'd1, 32'h107);
        wr(2'd2, 7);
        wr(2'd3, pk(16'h100, 16'h0100)); wr(2'd3, pk(16'h200, 16'h0200));
        wr(2'd2, 7);
        wr(2'd3, pk(16'h0A1, 16'h0A11)); wr(2'd3, pk(16'h0A2, 16'h0A22)); wr(2'd3, pk(16'h0A3, 16'h0A33));
        wr(2'd0, 1);
        frame();
        chk(live_status, 1, "R2 status bank A");
        look(5, 0, 0, 16'h2AAA, 16'h155, "R7 A e5 red");
        look(5, 2, 0, 16'h3FFF, 16'h3FF, "R7 A e5 blue");
        look(6, 1, 0, 0, 0, "R5 masked green untouched");
        look(6, 2, 0, 16'h0030, 16'h003, "R5 enabled blue written");
        look(7, 0, 0, 16'h0A11, 16'h0A1, "R8 index rewrite restarts entry red");
        look(7, 1, 0, 16'h0A22, 16'h0A2, "R8 index rewrite restarts entry green");

        // wrap from entry 31 into entry 0 of bank B
        wr(2'd1, 32'h117);
        wr(2'd2, 31);
        wr(2'd3, pk(16'h031, 16'h1F01)); wr(2'd3, pk(16'h032, 16'h1F02)); wr(2'd3, pk(16'h033, 16'h1F03));
        wr(2'd3, pk(16'h040, 16'h0400)); wr(2'd3, pk(16'h041, 16'h0401)); wr(2'd3, pk(16'h042, 16'h0402));
        wr(2'd0, 2);
        frame();
        look(31, 2, 0, 16'h1F03, 16'h033, "R11 B e31 blue");
        look(0, 0, 0, 16'h0400, 16'h040, "R11 wrapped into e0");
        look(1, 1, 0, 16'h2222, 16'h0BB, "R11 e1 untouched");

        // mode 3 behaves as bypass
        wr(2'd0, 3);
        frame();
        chk(live_status, 0, "R2 mode3 status");
        look(4, 1, 16'h2BCD, 16'h2BCD, 0, "R2 mode3 pass-through");

        // rejected writes to the live bank
        chk(wr_err, 0, "R9 err clear before");
        wr(2'd0, 1);
        frame();
        wr(2'd1, 32'h107);
        wr(2'd2, 5);
        wr(2'd3, pk(16'h3AA, 16'h0555)); wr(2'd3, pk(16'h3AB, 16'h0556)); wr(2'd3, pk(16'h3AC, 16'h0557));
        chk(wr_err, 1, "R9 err set");
        wr(2'd1, 32'h117);
        wr(2'd3, pk(16'h077, 16'h0777)); wr(2'd3, pk(16'h078, 16'h0778)); wr(2'd3, pk(16'h079, 16'h0779));
        look(5, 0, 0, 16'h2AAA, 16'h155, "R9 live bank unchanged");
        wr(2'd0, 2);
        look(5, 0, 0, 16'h2AAA, 16'h155, "R3 lookup source held until frame");
        frame();
        look(6, 0, 0, 16'h0777, 16'h077, "R9 index advanced past rejected entry");
        look(5, 0, 0, 0, 0, "R9 B e5 never written");
        repeat (3) @(negedge clk);
        chk(wr_err, 1, "R9 err sticky");
        chk(exp_q.size(), 0, "R10 scoreboard drained");
        finish_run();
    end

endmodule